// File: doc/BRIEF.md
# Three-Level Block Transfer Address Sequencer

This block turns a three-level transfer description into a stream of byte address pairs. The smallest unit is a row of ACNT bytes. BCNT rows make up a frame, and CCNT frames make up the whole block. A parameter set is loaded while the sequencer is idle. It holds:

- the source and destination start addresses;
- the three counts and a row-count reload value;
- four signed steps: a row step and a frame step, each kept for source and for destination;
- a sync mode.

Each sync event starts one burst. In row mode a burst covers one row. In frame mode it covers every row of the current frame. Each burst emits one read/write address pair per byte over a valid/ready handshake.

When the last pair of a burst is accepted, the sequencer updates its counts and its current start addresses. It then raises a one-cycle pulse: an intermediate pulse while frames remain, or a final pulse when the frame count reaches zero. The current frame count and row count are visible as outputs. A controller can read them and re-trigger the next burst.

If a sync event arrives while a burst is still running, it is not queued. Instead it sets a sticky error flag, which the controller clears with a one-cycle clear strobe. An event that finds any count at zero is a null transfer: it emits no addresses and completes at once.

Top module: `dma3d_addr_seq`

## Requirements
- R1: After reset the following are all low: busy, addr_valid, int_done, fin_done and miss_err. cur_ccnt and cur_bcnt read zero.
- R2: cfg_load with busy low and sync_evt low latches the parameter set, and cur_ccnt and cur_bcnt show the loaded counts one cycle later. cfg_load while busy, or together with sync_evt, changes nothing.
- R3: In row mode (cfg_frame_sync=0) an event emits ACNT pairs. Pair k is (row source start + k, row destination start + k). A pair holds stable while addr_valid is high and addr_ready is low.
- R4: In frame mode (cfg_frame_sync=1) an event emits the current BCNT rows back to back. Row j starts at the frame start plus j times the row step, separately for source and destination. Each row is ACNT consecutive bytes.
- R5: After a row-mode burst with row count above one, both start addresses advance by their row steps and the row count drops by one. With row count equal to one, they advance by their frame steps, the row count takes the reload value, and the frame count drops by one.
- R6: After a frame-mode burst, both frame start addresses advance by their frame steps and the frame count drops by one. The row count is unchanged.
- R7: One cycle after the last pair of a burst is accepted, int_done pulses for one cycle if the frame count is still nonzero.
- R8: One cycle after the last pair of a burst that brings the frame count to zero, fin_done pulses for one cycle. int_done and fin_done are never high together.
- R9: An event accepted while ACNT, the row count or the frame count is zero emits no pairs. busy stays low, fin_done pulses one cycle later, and the counts are unchanged.
- R10: sync_evt while busy sets miss_err one cycle later and starts no extra burst. miss_err stays set until err_clr, and a new miss wins over err_clr in the same cycle.
- R11: busy is high from the cycle after an accepted non-null event until the last pair is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load | input | 1 | Load the parameter set when idle |
| cfg_src_base | input | ADDR_W | Source start address |
| cfg_dst_base | input | ADDR_W | Destination start address |
| cfg_acnt | input | CNT_W | Bytes per row |
| cfg_bcnt | input | CNT_W | Rows per frame |
| cfg_ccnt | input | CNT_W | Frames per block |
| cfg_bcnt_rld | input | CNT_W | Row count reload value (row mode) |
| cfg_src_bstep | input | IDX_W | Signed source row step |
| cfg_src_cstep | input | IDX_W | Signed source frame step |
| cfg_dst_bstep | input | IDX_W | Signed destination row step |
| cfg_dst_cstep | input | IDX_W | Signed destination frame step |
| cfg_frame_sync | input | 1 | 0: one row per event, 1: one frame per event |
| sync_evt | input | 1 | Sync event strobe |
| err_clr | input | 1 | Clears miss_err |
| addr_valid | output | 1 | Address pair valid |
| addr_ready | input | 1 | Address pair accepted |
| rd_addr | output | ADDR_W | Byte read address |
| wr_addr | output | ADDR_W | Byte write address |
| busy | output | 1 | Burst in progress |
| int_done | output | 1 | Intermediate completion pulse |
| fin_done | output | 1 | Final completion pulse |
| miss_err | output | 1 | Sticky missed-event flag |
| cur_ccnt | output | CNT_W | Current frame count |
| cur_bcnt | output | CNT_W | Current row count |

## Verification
The properties assume that the consumer of address pairs is free to stall, but that cfg_load is held off while a burst runs. Loads while busy are dropped by the design anyway. The step property on cur_ccnt excludes the cycle after any load, so reloading with an arbitrary count does not trip it. The stimulus loads parameters only between bursts, apart from one deliberate load during a burst. It fires events only when idle, apart from one deliberate miss. It keeps counts small and draws random stalls on addr_ready, so every burst completes well within the run.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;

  typedef enum logic {
    SYNC_ROW   = 1'b0,
    SYNC_FRAME = 1'b1
  } sync_mode_e;

  localparam int NUM_STEPS = 4;
  localparam int STEP_SRC_ROW = 0;
  localparam int STEP_SRC_FRM = 1;
  localparam int STEP_DST_ROW = 2;
  localparam int STEP_DST_FRM = 3;

endpackage

// File: rtl/dma3d_rst_sync.sv
module dma3d_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/dma3d_ctx.sv
module dma3d_ctx
  import dma3d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              adv_en,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic [CNT_W-1:0]  cfg_acnt,
  input  logic [CNT_W-1:0]  cfg_bcnt,
  input  logic [CNT_W-1:0]  cfg_ccnt,
  input  logic [CNT_W-1:0]  cfg_brld,
  input  logic [IDX_W-1:0]  cfg_step [NUM_STEPS],
  input  sync_mode_e        cfg_mode,
  output logic [ADDR_W-1:0] base_src,
  output logic [ADDR_W-1:0] base_dst,
  output logic [CNT_W-1:0]  acnt,
  output logic [CNT_W-1:0]  bcnt,
  output logic [CNT_W-1:0]  ccnt,
  output logic [ADDR_W-1:0] row_step_src,
  output logic [ADDR_W-1:0] row_step_dst,
  output sync_mode_e        mode,
  output logic              frame_end,
  output logic              last_frame,
  output logic              null_xfer
);

  localparam int EXT_W = (ADDR_W > IDX_W) ? (ADDR_W - IDX_W) : 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [ADDR_W-1:0] src_q, src_d, dst_q, dst_d;
  logic [CNT_W-1:0]  a_q, a_d, b_q, b_d, c_q, c_d, rld_q, rld_d;
  logic [IDX_W-1:0]  step_q [NUM_STEPS];
  logic [IDX_W-1:0]  step_d [NUM_STEPS];
  logic [ADDR_W-1:0] step_ext [NUM_STEPS];
  sync_mode_e        mode_q, mode_d;
  logic              upd_en;

  // sign-extend each step to address width
  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_ext
    if (ADDR_W > IDX_W) begin : g_wide
      assign step_ext[g] = {{EXT_W{step_q[g][IDX_W-1]}}, step_q[g]};
    end else begin : g_narrow
      assign step_ext[g] = step_q[g][ADDR_W-1:0];
    end
  end

  assign frame_end  = (mode_q == SYNC_FRAME) || (b_q == ONE);
  assign last_frame = frame_end && (c_q == ONE);
  assign null_xfer  = (a_q == '0) || (b_q == '0) || (c_q == '0);
  assign upd_en     = load_en || adv_en;

  always_comb begin
    src_d  = src_q;
    dst_d  = dst_q;
    a_d    = a_q;
    b_d    = b_q;
    c_d    = c_q;
    rld_d  = rld_q;
    mode_d = mode_q;
    for (int i = 0; i < NUM_STEPS; i++) step_d[i] = step_q[i];
    if (load_en) begin
      src_d  = cfg_src;
      dst_d  = cfg_dst;
      a_d    = cfg_acnt;
      b_d    = cfg_bcnt;
      c_d    = cfg_ccnt;
      rld_d  = cfg_brld;
      mode_d = cfg_mode;
      for (int i = 0; i < NUM_STEPS; i++) step_d[i] = cfg_step[i];
    end else if (adv_en) begin
      if (frame_end) begin
        src_d = src_q + step_ext[STEP_SRC_FRM];
        dst_d = dst_q + step_ext[STEP_DST_FRM];
        c_d   = c_q - ONE;
        if (mode_q == SYNC_ROW) b_d = rld_q;
      end else begin
        src_d = src_q + step_ext[STEP_SRC_ROW];
        dst_d = dst_q + step_ext[STEP_DST_ROW];
        b_d   = b_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      c_q    <= '0;
      rld_q  <= '0;
      mode_q <= SYNC_ROW;
      for (int i = 0; i < NUM_STEPS; i++) step_q[i] <= '0;
    end else if (upd_en) begin
      src_q  <= src_d;
      dst_q  <= dst_d;
      a_q    <= a_d;
      b_q    <= b_d;
      c_q    <= c_d;
      rld_q  <= rld_d;
      mode_q <= mode_d;
      for (int i = 0; i < NUM_STEPS; i++) step_q[i] <= step_d[i];
    end
  end

  assign base_src     = src_q;
  assign base_dst     = dst_q;
  assign acnt         = a_q;
  assign bcnt         = b_q;
  assign ccnt         = c_q;
  assign row_step_src = step_ext[STEP_SRC_ROW];
  assign row_step_dst = step_ext[STEP_DST_ROW];
  assign mode         = mode_q;

endmodule

// File: rtl/dma3d_beat.sv
module dma3d_beat #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] src0,
  input  logic [ADDR_W-1:0] dst0,
  input  logic [CNT_W-1:0]  acnt,
  input  logic [CNT_W-1:0]  nrows,
  input  logic [ADDR_W-1:0] step_src,
  input  logic [ADDR_W-1:0] step_dst,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              last_acc
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic              valid_q, valid_d;
  logic [ADDR_W-1:0] rs_q, rs_d, ws_q, ws_d;
  logic [CNT_W-1:0]  off_q, off_d, left_q, left_d;
  logic              acc, row_end, burst_end, upd_en;

  assign acc       = valid_q && ready;
  assign row_end   = (off_q == (acnt - ONE));
  assign burst_end = row_end && (left_q == ONE);
  assign last_acc  = acc && burst_end;
  assign upd_en    = start || acc;

  always_comb begin
    valid_d = valid_q;
    rs_d    = rs_q;
    ws_d    = ws_q;
    off_d   = off_q;
    left_d  = left_q;
    if (start) begin
      valid_d = 1'b1;
      rs_d    = src0;
      ws_d    = dst0;
      off_d   = '0;
      left_d  = nrows;
    end else if (acc) begin
      if (row_end) begin
        off_d = '0;
        if (left_q == ONE) begin
          valid_d = 1'b0;
        end else begin
          left_d = left_q - ONE;
          rs_d   = rs_q + step_src;
          ws_d   = ws_q + step_dst;
        end
      end else begin
        off_d = off_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rs_q    <= '0;
      ws_q    <= '0;
      off_q   <= '0;
      left_q  <= '0;
    end else if (upd_en) begin
      valid_q <= valid_d;
      rs_q    <= rs_d;
      ws_q    <= ws_d;
      off_q   <= off_d;
      left_q  <= left_d;
    end
  end

  assign valid   = valid_q;
  assign rd_addr = rs_q + ADDR_W'(off_q);
  assign wr_addr = ws_q + ADDR_W'(off_q);

endmodule

// File: rtl/dma3d_addr_seq.sv
module dma3d_addr_seq
  import dma3d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_src_base,
  input  logic [ADDR_W-1:0] cfg_dst_base,
  input  logic [CNT_W-1:0]  cfg_acnt,
  input  logic [CNT_W-1:0]  cfg_bcnt,
  input  logic [CNT_W-1:0]  cfg_ccnt,
  input  logic [CNT_W-1:0]  cfg_bcnt_rld,
  input  logic [IDX_W-1:0]  cfg_src_bstep,
  input  logic [IDX_W-1:0]  cfg_src_cstep,
  input  logic [IDX_W-1:0]  cfg_dst_bstep,
  input  logic [IDX_W-1:0]  cfg_dst_cstep,
  input  logic              cfg_frame_sync,
  input  logic              sync_evt,
  input  logic              err_clr,
  output logic              addr_valid,
  input  logic              addr_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              busy,
  output logic              int_done,
  output logic              fin_done,
  output logic              miss_err,
  output logic [CNT_W-1:0]  cur_ccnt,
  output logic [CNT_W-1:0]  cur_bcnt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic              rst_i;
  logic              burst_on, evt_take, start, load_en, last_acc;
  logic [ADDR_W-1:0] base_src, base_dst, row_step_src, row_step_dst;
  logic [CNT_W-1:0]  acnt, bcnt, ccnt, nrows;
  sync_mode_e        mode;
  logic              frame_end, last_frame, null_xfer;
  logic [IDX_W-1:0]  steps [NUM_STEPS];
  logic              int_q, int_d, fin_q, fin_d, miss_q, miss_d;

  assign steps[STEP_SRC_ROW] = cfg_src_bstep;
  assign steps[STEP_SRC_FRM] = cfg_src_cstep;
  assign steps[STEP_DST_ROW] = cfg_dst_bstep;
  assign steps[STEP_DST_FRM] = cfg_dst_cstep;

  dma3d_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i)
  );

  assign evt_take = sync_evt && !burst_on;
  assign start    = evt_take && !null_xfer;
  assign load_en  = cfg_load && !burst_on && !sync_evt;
  assign nrows    = (mode == SYNC_FRAME) ? bcnt : ONE;

  dma3d_ctx #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ctx (
    .clk          (clk),
    .rst_n        (rst_i),
    .load_en      (load_en),
    .adv_en       (last_acc),
    .cfg_src      (cfg_src_base),
    .cfg_dst      (cfg_dst_base),
    .cfg_acnt     (cfg_acnt),
    .cfg_bcnt     (cfg_bcnt),
    .cfg_ccnt     (cfg_ccnt),
    .cfg_brld     (cfg_bcnt_rld),
    .cfg_step     (steps),
    .cfg_mode     (sync_mode_e'(cfg_frame_sync)),
    .base_src     (base_src),
    .base_dst     (base_dst),
    .acnt         (acnt),
    .bcnt         (bcnt),
    .ccnt         (ccnt),
    .row_step_src (row_step_src),
    .row_step_dst (row_step_dst),
    .mode         (mode),
    .frame_end    (frame_end),
    .last_frame   (last_frame),
    .null_xfer    (null_xfer)
  );

  dma3d_beat #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_beat (
    .clk      (clk),
    .rst_n    (rst_i),
    .start    (start),
    .src0     (base_src),
    .dst0     (base_dst),
    .acnt     (acnt),
    .nrows    (nrows),
    .step_src (row_step_src),
    .step_dst (row_step_dst),
    .ready    (addr_ready),
    .valid    (burst_on),
    .rd_addr  (rd_addr),
    .wr_addr  (wr_addr),
    .last_acc (last_acc)
  );

  always_comb begin
    int_d = last_acc && !last_frame;
    fin_d = (last_acc && last_frame) || (evt_take && null_xfer);
    if (sync_evt && burst_on) miss_d = 1'b1;
    else if (err_clr)         miss_d = 1'b0;
    else                      miss_d = miss_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      int_q  <= 1'b0;
      fin_q  <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      int_q  <= int_d;
      fin_q  <= fin_d;
      miss_q <= miss_d;
    end
  end

  assign addr_valid = burst_on;
  assign busy       = burst_on;
  assign int_done   = int_q;
  assign fin_done   = fin_q;
  assign miss_err   = miss_q;
  assign cur_ccnt   = ccnt;
  assign cur_bcnt   = bcnt;

  logic unused_ok;
  assign unused_ok = frame_end;

endmodule

// File: rtl/dma3d_addr_seq_chk.sv
module dma3d_addr_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_evt,
  input logic              err_clr,
  input logic              cfg_load,
  input logic              addr_valid,
  input logic              addr_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              busy,
  input logic              int_done,
  input logic              fin_done,
  input logic              miss_err,
  input logic [CNT_W-1:0]  cur_ccnt
);

  assert_pair_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !addr_ready |=> addr_valid && $stable(rd_addr) && $stable(wr_addr));

  assert_ccnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_ccnt) && !$past(cfg_load) |-> cur_ccnt == CNT_W'($past(cur_ccnt) - 1'b1));

  assert_int_after_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int_done |-> $past(busy) && !busy);

  assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_done && fin_done));

  assert_null_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt && !busy && cur_ccnt == '0 |=> fin_done && !busy);

  assert_miss_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt && busy |=> miss_err);

  assert_miss_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    miss_err && !err_clr |=> miss_err);

  assert_fin_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fin_done |-> !busy);

endmodule

bind dma3d_addr_seq dma3d_addr_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_i),
  .sync_evt   (sync_evt),
  .err_clr    (err_clr),
  .cfg_load   (cfg_load),
  .addr_valid (addr_valid),
  .addr_ready (addr_ready),
  .rd_addr    (rd_addr),
  .wr_addr    (wr_addr),
  .busy       (busy),
  .int_done   (int_done),
  .fin_done   (fin_done),
  .miss_err   (miss_err),
  .cur_ccnt   (cur_ccnt)
);

// File: tb/dma3d_addr_seq_test.sv
module dma3d_addr_seq_test;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, cfg_load, cfg_frame_sync, sync_evt, err_clr, addr_ready;
  logic [31:0] cfg_src_base, cfg_dst_base;
  logic [15:0] cfg_acnt, cfg_bcnt, cfg_ccnt, cfg_bcnt_rld;
  logic [15:0] cfg_src_bstep, cfg_src_cstep, cfg_dst_bstep, cfg_dst_cstep;
  logic        addr_valid, busy, int_done, fin_done, miss_err;
  logic [31:0] rd_addr, wr_addr;
  logic [15:0] cur_ccnt, cur_bcnt;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_src, m_dst;
  int          m_a, m_b, m_c, m_rld;
  logic [15:0] m_sb, m_sc, m_db, m_dc;
  bit          m_ab;

  dma3d_addr_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
    .cfg_acnt(cfg_acnt), .cfg_bcnt(cfg_bcnt), .cfg_ccnt(cfg_ccnt),
    .cfg_bcnt_rld(cfg_bcnt_rld),
    .cfg_src_bstep(cfg_src_bstep), .cfg_src_cstep(cfg_src_cstep),
    .cfg_dst_bstep(cfg_dst_bstep), .cfg_dst_cstep(cfg_dst_cstep),
    .cfg_frame_sync(cfg_frame_sync), .sync_evt(sync_evt), .err_clr(err_clr),
    .addr_valid(addr_valid), .addr_ready(addr_ready),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .busy(busy),
    .int_done(int_done), .fin_done(fin_done), .miss_err(miss_err),
    .cur_ccnt(cur_ccnt), .cur_bcnt(cur_bcnt)
  );

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic load_cfg(input logic [31:0] s, input logic [31:0] d, input int a,
                          input int b, input int c, input int rld,
                          input logic [15:0] sb, input logic [15:0] sc,
                          input logic [15:0] db, input logic [15:0] dc, input bit ab);
    cfg_src_base = s;  cfg_dst_base = d;
    cfg_acnt = 16'(a); cfg_bcnt = 16'(b); cfg_ccnt = 16'(c); cfg_bcnt_rld = 16'(rld);
    cfg_src_bstep = sb; cfg_src_cstep = sc; cfg_dst_bstep = db; cfg_dst_cstep = dc;
    cfg_frame_sync = ab;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    m_src = s; m_dst = d; m_a = a; m_b = b; m_c = c; m_rld = rld;
    m_sb = sb; m_sc = sc; m_db = db; m_dc = dc; m_ab = ab;
    chk(cur_ccnt == 16'(c), "R2 ccnt loaded", 32'(cur_ccnt), 32'(c));
    chk(cur_bcnt == 16'(b), "R2 bcnt loaded", 32'(cur_bcnt), 32'(b));
  endtask

  task automatic run_event(input bit inj_miss, input bit inj_load);
    bit          nul, fin_exp, stuck;
    int          nrows, guard;
    logic [31:0] es, ed;
    nul = (m_a == 0) || (m_b == 0) || (m_c == 0);
    nrows = m_ab ? m_b : 1;
    stuck = 1'b0;
    sync_evt = 1'b1;
    @(negedge clk);
    sync_evt = 1'b0;
    if (nul) begin
      chk(fin_done === 1'b1, "R9 null fin pulse", 32'(fin_done), 1);
      chk(busy === 1'b0 && addr_valid === 1'b0, "R9 no pairs", 32'({busy, addr_valid}), 0);
      chk(cur_ccnt == 16'(m_c), "R9 ccnt kept", 32'(cur_ccnt), 32'(m_c));
      @(negedge clk);
      return;
    end
    chk(busy === 1'b1, "R11 busy after event", 32'(busy), 1);
    if (inj_miss) begin
      addr_ready = 1'b0;
      sync_evt = 1'b1;
      @(negedge clk);
      sync_evt = 1'b0;
      chk(miss_err === 1'b1, "R10 miss set", 32'(miss_err), 1);
    end
    if (inj_load) begin
      addr_ready = 1'b0;
      cfg_ccnt = 16'(m_c + 7);
      cfg_bcnt = 16'(m_b + 3);
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
      chk(cur_ccnt == 16'(m_c), "R2 load ignored while busy", 32'(cur_ccnt), 32'(m_c));
    end
    for (int j = 0; j < nrows && !stuck; j++) begin
      for (int k = 0; k < m_a && !stuck; k++) begin
        es = m_src + sx(m_sb) * 32'(j) + 32'(k);
        ed = m_dst + sx(m_db) * 32'(j) + 32'(k);
        guard = 0;
        forever begin
          addr_ready = ($urandom_range(3) != 0);
          if (addr_valid && addr_ready) break;
          @(negedge clk);
          guard++;
          if (guard > 500) begin
            chk(1'b0, "R11 burst stalled", 32'(guard), 0);
            stuck = 1'b1;
            break;
          end
        end
        if (!stuck) begin
          chk(rd_addr == es, m_ab ? "R4 read addr" : "R3 read addr", rd_addr, es);
          chk(wr_addr == ed, m_ab ? "R4 write addr" : "R3 write addr", wr_addr, ed);
          @(negedge clk);
        end
      end
    end
    addr_ready = 1'b0;
    if (m_ab || m_b == 1) begin
      m_src = m_src + sx(m_sc);
      m_dst = m_dst + sx(m_dc);
      m_c   = m_c - 1;
      if (!m_ab) m_b = m_rld;
    end else begin
      m_src = m_src + sx(m_sb);
      m_dst = m_dst + sx(m_db);
      m_b   = m_b - 1;
    end
    fin_exp = (m_c == 0);
    chk(busy === 1'b0, "R11 idle after burst", 32'(busy), 0);
    chk(int_done === !fin_exp, "R7 intermediate pulse", 32'(int_done), 32'(!fin_exp));
    chk(fin_done === fin_exp, "R8 final pulse", 32'(fin_done), 32'(fin_exp));
    chk(cur_ccnt == 16'(m_c), m_ab ? "R6 ccnt update" : "R5 ccnt update",
        32'(cur_ccnt), 32'(m_c));
    chk(cur_bcnt == 16'(m_b), m_ab ? "R6 bcnt kept" : "R5 bcnt update",
        32'(cur_bcnt), 32'(m_b));
    @(negedge clk);
    chk(int_done === 1'b0 && fin_done === 1'b0, "R7 R8 single-cycle pulse",
        32'({int_done, fin_done}), 0);
  endtask

  initial begin
    #(20 * 190000);
    n_fail++;
    $display("FAIL R11 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rst_n = 1'b0; cfg_load = 1'b0; sync_evt = 1'b0; err_clr = 1'b0; addr_ready = 1'b0;
    cfg_src_base = '0; cfg_dst_base = '0; cfg_acnt = '0; cfg_bcnt = '0; cfg_ccnt = '0;
    cfg_bcnt_rld = '0; cfg_src_bstep = '0; cfg_src_cstep = '0; cfg_dst_bstep = '0;
    cfg_dst_cstep = '0; cfg_frame_sync = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk({busy, addr_valid, int_done, fin_done, miss_err} == 5'b0, "R1 flags low",
        32'({busy, addr_valid, int_done, fin_done, miss_err}), 0);
    chk(cur_ccnt == 16'd0 && cur_bcnt == 16'd0, "R1 counts zero",
        {cur_ccnt, cur_bcnt}, 0);

    // row mode, contiguous layout, reload equals row count
    load_cfg(32'h1000, 32'h8000, 3, 2, 2, 2, 16'd3, 16'd3, 16'd3, 16'd3, 1'b0);
    repeat (4) run_event(1'b0, 1'b0);
    run_event(1'b0, 1'b0); // R9: frame count is zero now

    // frame mode, negative frame step, a missed event and a dropped load
    load_cfg(32'h2000_0000, 32'h3000_0100, 2, 3, 2, 3, 16'd5, 16'hFFD8, 16'd4, 16'd100, 1'b1);
    run_event(1'b1, 1'b0);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    chk(miss_err === 1'b0, "R10 miss cleared", 32'(miss_err), 0);
    run_event(1'b0, 1'b1);

    // row mode where the reload differs from the first row count
    load_cfg(32'h500, 32'h900, 1, 1, 2, 3, 16'h0010, 16'hFFF0, 16'h0002, 16'h0020, 1'b0);
    while (m_c != 0) run_event(1'b0, 1'b0);

    // zero bytes per row: null transfer keeps the counts
    load_cfg(32'h40, 32'h80, 0, 2, 2, 2, 16'd1, 16'd1, 16'd1, 16'd1, 1'b0);
    run_event(1'b0, 1'b0);
    chk(cur_bcnt == 16'd2, "R9 bcnt kept", 32'(cur_bcnt), 2);

    // random parameter sets
    for (int it = 0; it < 16; it++) begin
      load_cfg($urandom(), $urandom(),
               $urandom_range(4, 1), $urandom_range(3, 1), $urandom_range(3, 1),
               $urandom_range(3, 1),
               16'($urandom_range(64)) - 16'd32, 16'($urandom_range(512)) - 16'd256,
               16'($urandom_range(64)) - 16'd32, 16'($urandom_range(512)) - 16'd256,
               1'($urandom_range(1)));
      while (m_c != 0) run_event(1'b0, 1'b0);
      run_event(1'b0, 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule